// File: doc/BRIEF.md
# I2C Master Byte-Step Transmitter

This block is an I2C master that only transmits and uses 7-bit addresses. It runs one host command at a time, and each command moves exactly one data byte. A host writes a slave address, a data byte and a control word over a small register port. Setting the launch bit in the control word starts one step. If the bus is idle, that step produces a start condition, then the address byte with its direction bit, then the data byte. The slave's acknowledge is sampled after each byte. If the bus is already held, the step sends only the data byte.

The continue bit chooses what happens after the byte's acknowledge slot:

- With continue set, the engine holds SCL low. It then waits for the next command without releasing the bus.
- With continue clear, it sends a stop condition and frees the bus.

Completion and the two acknowledge failures are reported as sticky flags. The host clears them by writing ones.

The SCL period is four quarter-periods. Each quarter-period is `QTR_DIV` clock cycles long. Both lines are open-drain: the outputs only say "pull low".

Top module: `i2c_step_master`

## Requirements
- R1: After reset, both pull-low outputs are 0, the status register (offset 3) reads 0 and the control register (offset 0) reads 0.
- R2: Writing control (offset 0) with bit 2 = 1 on an idle bus sends a start condition, then the 8-bit contents of the address register (offset 1, direction in bit 0, 0 = write), then the data register (offset 2). Each byte is sent MSB first and is followed by an acknowledge slot.
- R3: When control bit 1 (continue) was 1 for a step, no stop follows it. SCL stays pulled low, and the next launch sends only the data byte, with no start and no address.
- R4: When control bit 1 was 0 for a step, a stop condition follows the data acknowledge slot. Both lines are then released.
- R5: Status bit 0 (byte done) is set when each step's data acknowledge slot ends. It stays set until the host writes 1 to status bit 0; writing 0 there leaves it set.
- R6: Status bit 1 is set when the address byte is not acknowledged. It is sticky and cleared by writing 1 to it.
- R7: Status bit 2 is set when a data byte is not acknowledged. It is sticky and cleared by writing 1 to it.
- R8: Control bit 2 reads back as 1 while a step runs and clears itself when the step's byte completes.
- R9: A control write while a step is running (start, address, data or stop in progress) has no effect.
- R10: SDA changes while SCL is high only for start and stop conditions. Every other SDA change happens while SCL is low.
- R11: A launch after a stop sends a fresh start condition and the address byte again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset (0 control, 1 address, 2 data, 3 status) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| sda_in | input | 1 | Sampled SDA line level |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The checker assumes the host never writes the control register in the single cycle between its own launch write and the engine leaving idle. The bench keeps to this by waiting many cycles between any two control writes. The SDA-stability property assumes that no other agent moves SCL, because clock stretching is not modelled. The slave model in the bench therefore pulls only SDA, and changes it only on SCL falling edges.

// File: rtl/i2c_step_pkg.sv
package i2c_step_pkg;

    localparam logic [1:0] OFS_CTRL = 2'd0;
    localparam logic [1:0] OFS_SADR = 2'd1;
    localparam logic [1:0] OFS_DATA = 2'd2;
    localparam logic [1:0] OFS_STAT = 2'd3;

    localparam int CTL_GO   = 2;
    localparam int CTL_CONT = 1;
    localparam int STS_DONE = 0;
    localparam int STS_ANAK = 1;
    localparam int STS_DNAK = 2;

    localparam logic [3:0] ACK_SLOT = 4'd8;

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_ADDR, ST_DATA, ST_STOP, ST_HOLD
    } eng_state_e;

    typedef struct packed {
        eng_state_e  st;
        logic [1:0]  ph;
        logic [3:0]  bitn;
        logic [7:0]  shreg;
        logic        scl_low;
        logic        sda_low;
        logic        nak;
    } eng_regs_t;

    typedef struct packed {
        logic       go;
        logic       cont;
        logic [7:0] sadr;
        logic [7:0] data;
        logic       done;
        logic       anak;
        logic       dnak;
    } ctl_regs_t;

endpackage

// File: rtl/i2c_step_tick.sv
module i2c_step_tick #(
    parameter int QTR_DIV = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (QTR_DIV > 1) ? $clog2(QTR_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(QTR_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/i2c_step_engine.sv
module i2c_step_engine
    import i2c_step_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       go,
    input  logic       cont,
    input  logic [7:0] addr_byte,
    input  logic [7:0] data_byte,
    input  logic       sda_in,
    output logic       scl_low,
    output logic       sda_low,
    output logic       busy,
    output logic       hold,
    output logic       in_byte,
    output logic       step_done,
    output logic       addr_nak_set,
    output logic       data_nak_set
);
    localparam eng_regs_t ENG_RST = '{st: ST_IDLE, ph: 2'd0, bitn: 4'd0,
                                      shreg: 8'd0, scl_low: 1'b0,
                                      sda_low: 1'b0, nak: 1'b0};

    eng_regs_t d, q;

    assign scl_low = q.scl_low;
    assign sda_low = q.sda_low;
    assign busy    = (q.st != ST_IDLE) && (q.st != ST_HOLD);
    assign hold    = (q.st == ST_HOLD);
    assign in_byte = (q.st == ST_ADDR) || (q.st == ST_DATA);

    always_comb begin
        d            = q;
        step_done    = 1'b0;
        addr_nak_set = 1'b0;
        data_nak_set = 1'b0;
        case (q.st)
            ST_IDLE: begin
                d.scl_low = 1'b0;
                d.sda_low = 1'b0;
                if (go) begin
                    d.st = ST_START;
                    d.ph = 2'd0;
                end
            end
            ST_HOLD: begin
                d.scl_low = 1'b1;
                if (go) begin
                    d.st    = ST_DATA;
                    d.ph    = 2'd0;
                    d.bitn  = 4'd0;
                    d.shreg = data_byte;
                end
            end
            ST_START: if (tick) begin
                case (q.ph)
                    2'd0:    begin d.sda_low = 1'b1; d.ph = 2'd1; end
                    2'd1:    begin d.scl_low = 1'b1; d.ph = 2'd2; end
                    default: begin
                        d.st    = ST_ADDR;
                        d.ph    = 2'd0;
                        d.bitn  = 4'd0;
                        d.shreg = addr_byte;
                    end
                endcase
            end
            ST_ADDR, ST_DATA: if (tick) begin
                case (q.ph)
                    2'd0: begin
                        d.sda_low = (q.bitn == ACK_SLOT) ? 1'b0 : !q.shreg[7];
                        d.ph      = 2'd1;
                    end
                    2'd1: begin d.scl_low = 1'b0; d.ph = 2'd2; end
                    2'd2: begin
                        if (q.bitn == ACK_SLOT) d.nak = sda_in;
                        d.ph = 2'd3;
                    end
                    default: begin
                        d.scl_low = 1'b1;
                        d.ph      = 2'd0;
                        if (q.bitn != ACK_SLOT) begin
                            d.bitn  = q.bitn + 4'd1;
                            d.shreg = {q.shreg[6:0], 1'b0};
                        end else if (q.st == ST_ADDR) begin
                            addr_nak_set = q.nak;
                            d.st         = ST_DATA;
                            d.bitn       = 4'd0;
                            d.shreg      = data_byte;
                        end else begin
                            data_nak_set = q.nak;
                            step_done    = 1'b1;
                            d.st         = cont ? ST_HOLD : ST_STOP;
                        end
                    end
                endcase
            end
            ST_STOP: if (tick) begin
                case (q.ph)
                    2'd0:    begin d.sda_low = 1'b1; d.ph = 2'd1; end
                    2'd1:    begin d.scl_low = 1'b0; d.ph = 2'd2; end
                    2'd2:    begin d.sda_low = 1'b0; d.ph = 2'd3; end
                    default: begin d.st = ST_IDLE;   d.ph = 2'd0; end
                endcase
            end
            default: d = ENG_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= ENG_RST;
        else        q <= d;
    end
endmodule

// File: rtl/i2c_step_regs.sv
module i2c_step_regs
    import i2c_step_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    input  logic       busy,
    input  logic       step_done,
    input  logic       addr_nak_set,
    input  logic       data_nak_set,
    output logic [7:0] rdata,
    output logic       go,
    output logic       cont,
    output logic       done,
    output logic [7:0] slv_addr,
    output logic [7:0] tx_data
);
    ctl_regs_t d, q;

    assign go       = q.go;
    assign cont     = q.cont;
    assign done     = q.done;
    assign slv_addr = q.sadr;
    assign tx_data  = q.data;

    always_comb begin
        d = q;
        if (wr) begin
            case (addr)
                OFS_CTRL: if (!busy) begin
                    d.go   = wdata[CTL_GO];
                    d.cont = wdata[CTL_CONT];
                end
                OFS_SADR: d.sadr = wdata;
                OFS_DATA: d.data = wdata;
                default: begin
                    if (wdata[STS_DONE]) d.done = 1'b0;
                    if (wdata[STS_ANAK]) d.anak = 1'b0;
                    if (wdata[STS_DNAK]) d.dnak = 1'b0;
                end
            endcase
        end
        if (step_done) begin
            d.go   = 1'b0;
            d.done = 1'b1;
        end
        if (addr_nak_set) d.anak = 1'b1;
        if (data_nak_set) d.dnak = 1'b1;
    end

    always_comb begin
        rdata = 8'd0;
        case (addr)
            OFS_CTRL: begin
                rdata[CTL_GO]   = q.go;
                rdata[CTL_CONT] = q.cont;
            end
            OFS_SADR: rdata = q.sadr;
            OFS_DATA: rdata = q.data;
            default: begin
                rdata[STS_DONE] = q.done;
                rdata[STS_ANAK] = q.anak;
                rdata[STS_DNAK] = q.dnak;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/i2c_step_master.sv
module i2c_step_master #(
    parameter int QTR_DIV = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       sda_in,
    output logic       scl_drive_low,
    output logic       sda_drive_low
);
    logic       tick, busy, hold, in_byte, step_done;
    logic       addr_nak_set, data_nak_set;
    logic       go, cont, done;
    logic [7:0] slv_addr, tx_data;

    i2c_step_regs regs_i (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .busy(busy), .step_done(step_done),
        .addr_nak_set(addr_nak_set), .data_nak_set(data_nak_set),
        .rdata(reg_rdata), .go(go), .cont(cont), .done(done),
        .slv_addr(slv_addr), .tx_data(tx_data)
    );

    i2c_step_tick #(.QTR_DIV(QTR_DIV)) tick_i (
        .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
    );

    i2c_step_engine eng_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .go(go), .cont(cont),
        .addr_byte(slv_addr), .data_byte(tx_data), .sda_in(sda_in),
        .scl_low(scl_drive_low), .sda_low(sda_drive_low),
        .busy(busy), .hold(hold), .in_byte(in_byte),
        .step_done(step_done), .addr_nak_set(addr_nak_set),
        .data_nak_set(data_nak_set)
    );
endmodule

// File: rtl/i2c_step_master_chk.sv
module i2c_step_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [1:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic       scl_drive_low,
    input logic       sda_drive_low,
    input logic       busy,
    input logic       hold,
    input logic       in_byte,
    input logic       step_done,
    input logic       go,
    input logic       cont,
    input logic       done
);
    assert_hold_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> scl_drive_low);

    assert_idle_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !hold) |-> (!scl_drive_low && !sda_drive_low));

    assert_done_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !(reg_wr && reg_addr == 2'd3 && reg_wdata[0])) |=> done);

    assert_go_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        step_done |=> !go);

    assert_ctrl_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && reg_addr == 2'd0 && !step_done) |=> ($stable(go) && $stable(cont)));

    assert_sda_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_byte && $past(in_byte) && !scl_drive_low && $past(!scl_drive_low))
        |-> $stable(sda_drive_low));
endmodule

bind i2c_step_master i2c_step_master_chk chk_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .scl_drive_low(scl_drive_low),
    .sda_drive_low(sda_drive_low), .busy(busy), .hold(hold),
    .in_byte(in_byte), .step_done(step_done), .go(go), .cont(cont),
    .done(done)
);

// File: tb/i2c_step_master_tb_top.sv
module i2c_step_master_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       scl_drive_low, sda_drive_low;
    logic       slv_pull = 1'b0;
    logic       scl, sda;

    always #5 clk = ~clk;

    assign scl = !scl_drive_low;
    assign sda = !(sda_drive_low || slv_pull);

    i2c_step_master dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sda_in(sda),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low)
    );

    // slave model
    logic       ack_addr = 1'b1, ack_data = 1'b1;
    logic       p_scl = 1'b1, p_sda = 1'b1;
    int         starts = 0, stops = 0, hi_edges = 0, bitcnt = 0;
    logic       first = 1'b0, ackph = 1'b0;
    logic [7:0] shift = 8'd0, last_addr = 8'd0, last_data = 8'd0;

    always @(posedge clk) begin
        p_scl <= scl;
        p_sda <= sda;
        if (p_scl && scl && (p_sda != sda)) hi_edges <= hi_edges + 1;
        if (p_scl && scl && p_sda && !sda) begin
            starts <= starts + 1; bitcnt <= 0; first <= 1'b1; ackph <= 1'b0;
        end
        if (p_scl && scl && !p_sda && sda) stops <= stops + 1;
        if (!p_scl && scl && bitcnt < 8) begin
            shift  <= {shift[6:0], sda};
            bitcnt <= bitcnt + 1;
        end
        if (p_scl && !scl) begin
            if (bitcnt == 8 && !ackph) begin
                ackph    <= 1'b1;
                slv_pull <= first ? ack_addr : ack_data;
                if (first) last_addr <= shift; else last_data <= shift;
            end else if (ackph) begin
                ackph <= 1'b0; slv_pull <= 1'b0; bitcnt <= 0; first <= 1'b0;
            end
        end
    end

    int n_chk = 0, n_fail = 0;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_done();
        logic [7:0] s;
        for (int i = 0; i < 3000; i++) begin
            rd(2'd3, s);
            if (s[0]) break;
        end
    endtask

    // {sadr[7:0], data[7:0], cont, addr_ack, data_ack}
    localparam logic [18:0] VEC [8] = '{
        {8'hA0, 8'h3C, 1'b0, 1'b1, 1'b1},
        {8'hA0, 8'h81, 1'b1, 1'b1, 1'b1},
        {8'hA0, 8'h00, 1'b1, 1'b1, 1'b1},
        {8'hA0, 8'hFF, 1'b0, 1'b1, 1'b1},
        {8'hFC, 8'h55, 1'b0, 1'b0, 1'b1},
        {8'h42, 8'hA5, 1'b0, 1'b1, 1'b0},
        {8'h42, 8'h5A, 1'b1, 1'b1, 1'b0},
        {8'h42, 8'h13, 1'b0, 1'b1, 1'b1}
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired (R2) actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic       idle_before;
        int         exp_starts, exp_stops;
        exp_starts = 0; exp_stops = 0; idle_before = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd(2'd3, v); check("R1 status", v, 0);
        rd(2'd0, v); check("R1 control", v, 0);
        check("R1 scl/sda", {scl_drive_low, sda_drive_low}, 0);

        for (int k = 0; k < 8; k++) begin
            logic [7:0] sa, dt;
            logic c, aa, da;
            {sa, dt, c, aa, da} = VEC[k];
            ack_addr = aa; ack_data = da;
            wr(2'd1, sa); wr(2'd2, dt); wr(2'd3, 8'h07);
            wr(2'd0, {5'd0, 1'b1, c, 1'b0});
            repeat (20) @(negedge clk);
            rd(2'd0, v); check("R8 go set while running", v[2], 1);
            wait_done();
            rd(2'd3, v);
            check("R5 done", v[0], 1);
            check("R6 addr nak", v[1], idle_before & !aa);
            check("R7 data nak", v[2], !da);
            rd(2'd0, v); check("R8 go self-clear", v[2], 0);
            if (idle_before) exp_starts++;
            if (!c) exp_stops++;
            repeat (80) @(negedge clk);
            check("R2 data byte", last_data, dt);
            if (idle_before) check("R2/R11 address byte", last_addr, sa);
            check("R3/R11 start count", starts, exp_starts);
            check("R4 stop count", stops, exp_stops);
            if (c) check("R3 scl held", scl_drive_low, 1);
            else   check("R4 released", {scl_drive_low, sda_drive_low}, 0);
            idle_before = !c;
        end

        // R5 sticky: writing 0 keeps, writing 1 clears
        wr(2'd3, 8'h00); rd(2'd3, v); check("R5 kept on 0 write", v[0], 1);
        wr(2'd3, 8'h01); rd(2'd3, v); check("R5 cleared", v[0], 0);

        // R9 control write ignored while running
        ack_addr = 1'b1; ack_data = 1'b1;
        wr(2'd1, 8'h30); wr(2'd2, 8'hC3);
        wr(2'd0, 8'h04);
        repeat (30) @(negedge clk);
        wr(2'd0, 8'h06);
        wait_done();
        exp_starts++; exp_stops++;
        repeat (80) @(negedge clk);
        check("R9 stop still sent", stops, exp_stops);
        check("R9 released", {scl_drive_low, sda_drive_low}, 0);
        rd(2'd0, v); check("R9 control unchanged", v, 0);
        check("R9 no relaunch", starts, exp_starts);

        // R10 high-SCL SDA edges only at start/stop
        check("R10 sda edges with scl high", hi_edges, starts + stops);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule